// File: doc/BRIEF.md
# Conversion Trigger and Gate Controller

This block holds the control word of one scan-type conversion request source. It turns a selected external trigger input and a selected gate input into conversion start requests. A bus write port updates the word, and the current word can be read back at any time. Write-control bits inside the write data decide which field groups a given write may change. Those bits are never stored.

Two 16-way multiplexers each pick one trigger line and one gate line. Both selected levels pass through two-flop synchronizers. The synchronized trigger feeds an edge detector whose sensitivity comes from a 2-bit mode field. A qualifying edge produces a one-cycle start pulse when the gate is open or timer mode is on. The block also outputs the live gate level, the live trigger level, the forced result-register index and the timer-mode flag to the sequencer that follows.

Top module: `trigger_gate_ctrl`

## Requirements
- R1: After reset every field is 0: `ctrl_word` reads 0, `res_sel` is 0, `timer_mode` is 0 and `start_req` stays low.
- R2: With trigger mode 0 (`wr_data[9:8]`), no trigger edge of any kind produces `start_req`.
- R3: Trigger mode 1 reacts to falling edges, mode 2 to rising edges and mode 3 to both. Each qualifying edge gives a single one-cycle `start_req` pulse, seen in the third clock cycle after the input changes.
- R4: Trigger mode (`wr_data[9:8]`) and trigger select (`wr_data[7:4]`) are written only when `wr_data[10]` is 1 in the same write. Otherwise they keep their values.
- R5: Gate select (`wr_data[15:12]`) is written only when `wr_data[16]` is 1 in the same write.
- R6: Timer enable (`wr_data[20]`) is written only when `wr_data[21]` is 1 in the same write.
- R7: The result-register field (`wr_data[3:0]`) is written by every write and drives `res_sel`. A value of 0 leaves the choice to the per-channel setting, and a value from 1 to 15 forces that result register.
- R8: With timer mode off, a qualifying edge issues `start_req` only while the synchronized gate level is 1. With timer mode on, the gate level is ignored.
- R9: The write-control bits 10, 16 and 21 always read back as 0 in `ctrl_word`. All other unused bits also read 0.
- R10: `trig_level` and `gate_level` show `trig_in[trig_sel]` and `gate_in[gate_sel]` two clock cycles after a change.
- R11: Switching the trigger mode from 0 to an edge mode while the selected input is already high produces no `start_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data carrying fields and write-control bits |
| ctrl_word | output | 32 | Read-back of the stored control word |
| trig_in | input | 16 | External trigger candidates |
| gate_in | input | 16 | External gate candidates |
| start_req | output | 1 | One-cycle conversion start request |
| trig_level | output | 1 | Synchronized level of the selected trigger |
| gate_level | output | 1 | Synchronized level of the selected gate |
| res_sel | output | 4 | Forced result-register index, 0 = per-channel |
| timer_mode | output | 1 | Timer mode enabled |

## Verification
The edge detector is driven with a lone rising step and a lone falling step under each of the four modes. The pulse count and the cycle in which the pulse appears separate the modes from one another and confirm the three-cycle latency. Writes with and without each write-control bit show whether each field group is protected independently of the others. The gate is tested with a closed gate, with a closed gate plus timer mode, and with an open gate. A mode change made while the input is already high shows that the edge history does not produce a false start.

// File: rtl/trigger_gate_ctrl.sv
module trigger_gate_ctrl #(
  parameter int N_IN = 16,
  localparam int SW = $clog2(N_IN)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] ctrl_word,
  input  logic [15:0] trig_in,
  input  logic [15:0] gate_in,
  output logic        start_req,
  output logic        trig_level,
  output logic        gate_level,
  output logic [3:0]  res_sel,
  output logic        timer_mode
);
  logic [3:0]    res_q;
  logic [SW-1:0] trig_sel_q, gate_sel_q;
  logic [1:0]    mode_q;
  logic          tmr_q;
  logic          t_s1, t_s2, t_hist, g_s1, g_s2;
  logic          edge_hit, start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q      <= '0;
      trig_sel_q <= '0;
      mode_q     <= '0;
      gate_sel_q <= '0;
      tmr_q      <= 1'b0;
    end else if (wr_en) begin
      res_q <= wr_data[3:0];
      if (wr_data[10]) begin
        trig_sel_q <= wr_data[4 +: SW];
        mode_q     <= wr_data[9:8];
      end
      if (wr_data[16]) gate_sel_q <= wr_data[12 +: SW];
      if (wr_data[21]) tmr_q <= wr_data[20];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {t_s1, t_s2, t_hist, g_s1, g_s2} <= '0;
      start_q <= 1'b0;
    end else begin
      t_s1    <= trig_in[trig_sel_q];
      t_s2    <= t_s1;
      t_hist  <= t_s2;
      g_s1    <= gate_in[gate_sel_q];
      g_s2    <= g_s1;
      start_q <= edge_hit & (tmr_q | g_s2);
    end
  end

  always_comb begin
    unique case (mode_q)
      2'd1:    edge_hit = ~t_s2 & t_hist;
      2'd2:    edge_hit = t_s2 & ~t_hist;
      2'd3:    edge_hit = t_s2 ^ t_hist;
      default: edge_hit = 1'b0;
    endcase
  end

  assign ctrl_word  = {10'b0, 1'b0, tmr_q, 3'b0, 1'b0, gate_sel_q,
                       1'b0, 1'b0, mode_q, trig_sel_q, res_q};
  assign start_req  = start_q;
  assign trig_level = t_s2;
  assign gate_level = g_s2;
  assign res_sel    = res_q;
  assign timer_mode = tmr_q;
endmodule

module trigger_gate_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [1:0]  mode_q,
  input logic [3:0]  gate_sel_q,
  input logic        start_req,
  input logic        gate_level,
  input logic        timer_mode,
  input logic [3:0]  res_sel
);
  assert_no_start_mode_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == 2'd0 |=> !start_req);
  assert_trig_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[10]) |=> $stable(mode_q));
  assert_gate_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[16]) |=> $stable(gate_sel_q));
  assert_timer_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[21]) |=> $stable(timer_mode));
  assert_res_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> res_sel == $past(wr_data[3:0]));
  assert_gate_qual_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> $past(timer_mode || gate_level));
endmodule

bind trigger_gate_ctrl trigger_gate_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .mode_q(mode_q), .gate_sel_q(gate_sel_q), .start_req(start_req),
  .gate_level(gate_level), .timer_mode(timer_mode), .res_sel(res_sel)
);

// File: tb/test_trigger_gate_ctrl.sv
module test_trigger_gate_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] ctrl_word;
  logic [15:0] trig_in = '0;
  logic [15:0] gate_in = 16'h0001;
  logic        start_req, trig_level, gate_level, timer_mode;
  logic [3:0]  res_sel;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [31:0] TWC = 32'h0000_0400;
  localparam logic [31:0] GWC = 32'h0001_0000;
  localparam logic [31:0] MWC = 32'h0020_0000;

  trigger_gate_ctrl i_trigger_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_word(ctrl_word), .trig_in(trig_in), .gate_in(gate_in),
    .start_req(start_req), .trig_level(trig_level), .gate_level(gate_level),
    .res_sel(res_sel), .timer_mode(timer_mode)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic measure(output int first, output int cnt);
    first = 0; cnt = 0;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (start_req) begin
        cnt++;
        if (first == 0) first = i;
      end
    end
  endtask

  task automatic step(input int line, input logic v, output int first, output int cnt);
    @(negedge clk); trig_in[line] = v;
    measure(first, cnt);
  endtask

  task automatic t_reset();
    chk("R1 ctrl_word", ctrl_word, 0);
    chk("R1 res_sel", {28'b0, res_sel}, 0);
    chk("R1 timer_mode", {31'b0, timer_mode}, 0);
    chk("R1 start_req", {31'b0, start_req}, 0);
  endtask

  task automatic t_mode_off();
    int f, c, tot;
    tot = 0;
    @(negedge clk); trig_in = 16'hFFFF; measure(f, c); tot += c;
    @(negedge clk); trig_in = 16'h0000; measure(f, c); tot += c;
    chk("R2 no start in mode 0", tot, 0);
  endtask

  task automatic t_edges();
    int f, c;
    wr(TWC | (2 << 8) | (3 << 4));
    settle();
    step(3, 1, f, c);
    chk("R3 rising count", c, 1);
    chk("R3 rising latency", f, 3);
    step(3, 0, f, c);
    chk("R3 rising ignores fall", c, 0);
    wr(TWC | (1 << 8) | (3 << 4));
    settle();
    step(3, 1, f, c);
    chk("R3 falling ignores rise", c, 0);
    step(3, 0, f, c);
    chk("R3 falling count", c, 1);
    chk("R3 falling latency", f, 3);
    wr(TWC | (3 << 8) | (3 << 4));
    settle();
    step(3, 1, f, c);
    chk("R3 any edge rise", c, 1);
    step(3, 0, f, c);
    chk("R3 any edge fall", c, 1);
  endtask

  task automatic t_trig_protect();
    int f, c;
    wr((5 << 4));
    chk("R4 trig fields kept", ctrl_word[9:4], 6'h33);
    step(3, 1, f, c);
    chk("R4 old mode still active", c, 1);
    step(3, 0, f, c);
  endtask

  task automatic t_readback_timer();
    wr(32'hFFFF_FFFF);
    chk("R9 wc bits read 0", ctrl_word, 32'h0010_F3FF);
    chk("R6 timer set with wc", {31'b0, timer_mode}, 1);
    wr(32'h0000_0000);
    chk("R6 timer kept without wc", {31'b0, timer_mode}, 1);
    chk("R5 gate sel kept without wc", ctrl_word[15:12], 4'hF);
    wr(MWC);
    chk("R6 timer cleared with wc", {31'b0, timer_mode}, 0);
  endtask

  task automatic t_res();
    wr(32'h0000_0009);
    chk("R7 res_sel forced", {28'b0, res_sel}, 9);
    wr(32'h0000_0000);
    chk("R7 res_sel per-channel", {28'b0, res_sel}, 0);
  endtask

  task automatic t_gate();
    int f, c;
    wr(TWC | GWC | (2 << 12) | (2 << 8) | (3 << 4));
    @(negedge clk); gate_in = 16'h0000; trig_in = '0;
    settle();
    chk("R10 gate level low", {31'b0, gate_level}, 0);
    step(3, 1, f, c);
    chk("R8 closed gate blocks", c, 0);
    step(3, 0, f, c);
    wr(MWC | (1 << 20));
    step(3, 1, f, c);
    chk("R8 timer mode bypasses gate", c, 1);
    step(3, 0, f, c);
    wr(MWC);
    @(negedge clk); gate_in = 16'h0004;
    @(negedge clk);
    chk("R10 gate level after 1 cycle", {31'b0, gate_level}, 0);
    @(negedge clk);
    chk("R10 gate level after 2 cycles", {31'b0, gate_level}, 1);
    step(3, 1, f, c);
    chk("R8 open gate passes", c, 1);
  endtask

  task automatic t_trig_mux();
    wr(TWC | (7 << 4));
    @(negedge clk); trig_in = 16'h0080;
    @(negedge clk);
    chk("R10 trig level after 1 cycle", {31'b0, trig_level}, 0);
    @(negedge clk);
    chk("R10 trig level after 2 cycles", {31'b0, trig_level}, 1);
  endtask

  task automatic t_no_spurious();
    int f, c;
    settle();
    wr(TWC | (2 << 8) | (7 << 4));
    measure(f, c);
    chk("R11 no spurious start", c, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_off();
    t_edges();
    t_trig_protect();
    t_readback_timer();
    t_res();
    t_gate();
    t_trig_mux();
    t_no_spurious();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule